// File: doc/BRIEF.md
# Real-Time-Clock Interrupt Aggregator

This block merges the interrupt sources of a real-time clock into a single active-low interrupt line. The sources are watchdog expiry, alarm match, a set of timestamp channels, battery switch-over and a low-battery condition. Each source has its own status flag. An event input sets the flag, and an enable decides whether that flag can drive the interrupt line. The interrupt output is the inverted OR of all enabled flags. It is taken straight from the registered flags, so it follows their levels and has no pulsed form.

Software uses a small register port with three registers. The status register holds the flags. The enable register holds the per-source enables. The watchdog control register holds a two-bit field. Alarm, switch-over and timestamp flags are cleared by writing 0 to their bit, and writing 1 to a bit leaves it alone. This lets a read-modify-write sequence run without losing an event that arrives between the read and the write. The watchdog flag and the low-battery flag cannot be changed by writes. The watchdog flag clears only on a hardware restart strobe. The low-battery flag mirrors the live condition.

Top module: `rtc_irq_aggregator`

## Requirements
- R1: While `rst` is high on a clock edge, all flags, enables and the watchdog control field become 0, and `irq_n` reads 1 after that edge.
- R2: A high event input (`alarm_hit`, `bat_switched`, `wd_expire`, any `ts_event` bit) at a clock edge sets its flag at that edge, whatever the enables hold.
- R3: Status register (address 0) layout: bit 0 alarm, bit 1 switch-over, bit 2 watchdog, bit 3 low-battery, bit 4+i timestamp channel i, other bits 0. Writing 0 to bit 0, 1 or 4+i clears that flag. Writing 1 leaves it unchanged.
- R4: When an event and a clearing write to the same flag meet at one edge, the flag is set after that edge.
- R5: Writes never change the watchdog flag. `wd_restart` clears it. When `wd_expire` and `wd_restart` are high together, the flag is set.
- R6: The low-battery flag equals `bat_low` as sampled at the previous clock edge. Writes have no effect on it.
- R7: Enable register (address 1): bit 0 alarm, bit 1 switch-over, bit 2 all timestamp channels, bit 3 low-battery. The watchdog term is enabled when the field in bits 1:0 of address 2 is nonzero. `irq_n` = NOT( OR of each flag AND its enable ).
- R8: `irq_n` follows flag levels with no pulse behaviour. A clearing write, or a write that removes an enable, raises `irq_n` right after the edge that takes the write, provided no other enabled flag is set.
- R9: Address 1 reads its 4 enables in bits 3:0. Address 2 reads its field in bits 1:0. The upper bits of both read 0. Address 3 reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for read and write |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr` (combinational) |
| wd_expire | input | 1 | Watchdog expiry event |
| wd_restart | input | 1 | Watchdog restart strobe; clears the watchdog flag |
| alarm_hit | input | 1 | Alarm match event |
| ts_event | input | N_TS | Timestamp events, one per channel |
| bat_switched | input | 1 | Battery switch-over event |
| bat_low | input | 1 | Live low-battery condition level |
| irq_n | output | 1 | Active-low aggregated interrupt |

## Verification
The bench sweeps every combination of 64 flag patterns, 16 enable words and 4 watchdog field values. After each combination it issues an all-zero status write, so the clear path and the immune flags are checked against each other. A design that let the watchdog or low-battery flag fall to a write would show a missing bit and a raised `irq_n`. A design that treated the watchdog field as a single bit would miss the interrupt for field value 2. Directed cases cover an event colliding with a clear, expiry colliding with restart, and write-1 having no effect. A design that let the clear win a collision, or that cleared flags on a write of 1, would read back a wrong status.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;

    typedef enum logic [1:0] {
        REG_STATUS = 2'd0,
        REG_ENABLE = 2'd1,
        REG_WDCTL  = 2'd2,
        REG_NONE   = 2'd3
    } rtc_reg_e;

    // status bit positions
    localparam int BIT_ALARM  = 0;
    localparam int BIT_SWOVER = 1;
    localparam int BIT_WDOG   = 2;
    localparam int BIT_BATLOW = 3;
    localparam int BIT_TS0    = 4;

    localparam int EN_W    = 4;
    localparam int WDCTL_W = 2;

    typedef struct packed {
        logic batlow;
        logic ts;
        logic swover;
        logic alarm;
    } irq_en_t;

    function automatic logic wd_irq_on(input logic [WDCTL_W-1:0] field);
        return |field;
    endfunction

endpackage

// File: rtl/rtc_irq_flag.sv
module rtc_irq_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic flag
);

    always_ff @(posedge clk) begin
        if (rst)      flag <= 1'b0;
        else if (set) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end

    // R2 / R4: a set always lands, even against a clear
    assert_set_wins_R4: assert property (@(posedge clk) disable iff (rst)
        set |=> flag);

    // R3: a clear without a set empties the flag
    assert_clear_R3: assert property (@(posedge clk) disable iff (rst)
        (clr && !set) |=> !flag);

    // R3: without set or clear the flag holds
    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!clr && !set) |=> $stable(flag));

endmodule

// File: rtl/rtc_irq_regs.sv
module rtc_irq_regs
    import rtc_irq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr,
    input  logic [1:0]                addr,
    input  logic [EN_W-1:0]           wdata_lo,
    input  logic [DATA_W-1:0]         status_word,
    output irq_en_t                   en,
    output logic [WDCTL_W-1:0]        wd_ctl,
    output logic [DATA_W-1:0]         rdata
);

    always_ff @(posedge clk) begin
        if (rst) begin
            en     <= '0;
            wd_ctl <= '0;
        end else if (wr) begin
            if (addr == REG_ENABLE) en     <= irq_en_t'(wdata_lo);
            if (addr == REG_WDCTL)  wd_ctl <= wdata_lo[WDCTL_W-1:0];
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            REG_STATUS: rdata = status_word;
            REG_ENABLE: rdata[EN_W-1:0] = en;
            REG_WDCTL:  rdata[WDCTL_W-1:0] = wd_ctl;
            default:    rdata = '0;
        endcase
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (en == '0 && wd_ctl == '0));

    assert_en_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !(wr && addr == REG_ENABLE) |=> $stable(en));

    assert_ctl_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !(wr && addr == REG_WDCTL) |=> $stable(wd_ctl));

endmodule

// File: rtl/rtc_irq_combine.sv
module rtc_irq_combine
    import rtc_irq_pkg::*;
#(
    parameter int N_TS = 2
) (
    input  logic                alarm_f,
    input  logic                swover_f,
    input  logic                wdog_f,
    input  logic                batlow_f,
    input  logic [N_TS-1:0]     ts_f,
    input  irq_en_t             en,
    input  logic [WDCTL_W-1:0]  wd_ctl,
    output logic                irq_n
);

    localparam int N_TERMS = 5;
    logic [N_TERMS-1:0] terms;

    always_comb begin
        terms[0] = alarm_f  & en.alarm;
        terms[1] = swover_f & en.swover;
        terms[2] = wdog_f   & wd_irq_on(wd_ctl);
        terms[3] = batlow_f & en.batlow;
        terms[4] = (|ts_f)  & en.ts;
        irq_n    = ~(|terms);
    end

endmodule

// File: rtl/rtc_irq_aggregator.sv
module rtc_irq_aggregator
    import rtc_irq_pkg::*;
#(
    parameter int N_TS   = 2,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              wd_expire,
    input  logic              wd_restart,
    input  logic              alarm_hit,
    input  logic [N_TS-1:0]   ts_event,
    input  logic              bat_switched,
    input  logic              bat_low,
    output logic              irq_n
);

    localparam int N_CLR   = 2 + N_TS;
    localparam int STAT_W  = BIT_TS0 + N_TS;

    logic                status_wr;
    logic [N_CLR-1:0]    clr_set;
    logic [N_CLR-1:0]    clr_wipe;
    logic [N_CLR-1:0]    clr_flag;
    logic                wdog_f;
    logic                batlow_f;
    logic [DATA_W-1:0]   status_word;
    irq_en_t             en;
    logic [WDCTL_W-1:0]  wd_ctl;

    assign status_wr = reg_wr && (reg_addr == REG_STATUS);

    // clearable flags: 0 alarm, 1 switch-over, 2.. timestamp channels
    always_comb begin
        clr_set[0]  = alarm_hit;
        clr_set[1]  = bat_switched;
        clr_wipe[0] = status_wr && !reg_wdata[BIT_ALARM];
        clr_wipe[1] = status_wr && !reg_wdata[BIT_SWOVER];
        for (int i = 0; i < N_TS; i++) begin
            clr_set[2+i]  = ts_event[i];
            clr_wipe[2+i] = status_wr && !reg_wdata[BIT_TS0+i];
        end
    end

    for (genvar g = 0; g < N_CLR; g++) begin : g_clr
        rtc_irq_flag u_flag (
            .clk  (clk),
            .rst  (rst),
            .set  (clr_set[g]),
            .clr  (clr_wipe[g]),
            .flag (clr_flag[g])
        );
    end

    rtc_irq_flag u_wdog (
        .clk  (clk),
        .rst  (rst),
        .set  (wd_expire),
        .clr  (wd_restart),
        .flag (wdog_f)
    );

    always_ff @(posedge clk) begin
        if (rst) batlow_f <= 1'b0;
        else     batlow_f <= bat_low;
    end

    always_comb begin
        status_word = '0;
        status_word[BIT_ALARM]  = clr_flag[0];
        status_word[BIT_SWOVER] = clr_flag[1];
        status_word[BIT_WDOG]   = wdog_f;
        status_word[BIT_BATLOW] = batlow_f;
        status_word[STAT_W-1:BIT_TS0] = clr_flag[N_CLR-1:2];
    end

    rtc_irq_regs #(.DATA_W(DATA_W)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .wr          (reg_wr),
        .addr        (reg_addr),
        .wdata_lo    (reg_wdata[EN_W-1:0]),
        .status_word (status_word),
        .en          (en),
        .wd_ctl      (wd_ctl),
        .rdata       (reg_rdata)
    );

    rtc_irq_combine #(.N_TS(N_TS)) u_combine (
        .alarm_f  (clr_flag[0]),
        .swover_f (clr_flag[1]),
        .wdog_f   (wdog_f),
        .batlow_f (batlow_f),
        .ts_f     (clr_flag[N_CLR-1:2]),
        .en       (en),
        .wd_ctl   (wd_ctl),
        .irq_n    (irq_n)
    );

    initial begin
        assert (STAT_W <= DATA_W) else $error("status word does not fit DATA_W");
    end

    assert_reset_irq_R1: assert property (@(posedge clk)
        rst |=> irq_n);

    // R5: only expiry or restart move the watchdog flag
    assert_wd_write_immune_R5: assert property (@(posedge clk) disable iff (rst)
        (!wd_expire && !wd_restart) |=> $stable(wdog_f));

    assert_wd_expire_wins_R5: assert property (@(posedge clk) disable iff (rst)
        (wd_expire && wd_restart) |=> wdog_f);

    assert_batlow_track_R6: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (batlow_f == $past(bat_low)));

endmodule

// File: tb/test_rtc_irq_aggregator.sv
module test_rtc_irq_aggregator;

    localparam int CLK_PERIOD = 10;
    localparam int N_TS   = 2;
    localparam int DATA_W = 8;

    logic              clk = 1'b0;
    logic              rst;
    logic              reg_wr;
    logic [1:0]        reg_addr;
    logic [DATA_W-1:0] reg_wdata;
    logic [DATA_W-1:0] reg_rdata;
    logic              wd_expire, wd_restart, alarm_hit, bat_switched, bat_low;
    logic [N_TS-1:0]   ts_event;
    logic              irq_n;

    int vectors = 0;
    int fails   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_irq_aggregator #(.N_TS(N_TS), .DATA_W(DATA_W)) i_rtc_irq_aggregator (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .wd_expire(wd_expire), .wd_restart(wd_restart), .alarm_hit(alarm_hit),
        .ts_event(ts_event), .bat_switched(bat_switched), .bat_low(bat_low),
        .irq_n(irq_n)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic rd(input string req, input logic [1:0] a, input logic [7:0] exp);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick();
        rst = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
        wd_expire = 0; wd_restart = 0; alarm_hit = 0; ts_event = 0;
        bat_switched = 0; bat_low = 0;
        @(negedge clk);
        tick();
        rst = 1'b0;

        // R1 reset state
        check("R1 irq_n", irq_n, 1);
        rd("R1 status", 2'd0, 8'h00);
        rd("R1 enable", 2'd1, 8'h00);
        rd("R1 wdctl", 2'd2, 8'h00);

        // R2 flag sets with enable off; R7 enable gates
        alarm_hit = 1; tick(); alarm_hit = 0;
        rd("R2 alarm flag", 2'd0, 8'h01);
        check("R2 irq masked", irq_n, 1);
        wr(2'd1, 8'h01);
        check("R7 alarm enabled irq", irq_n, 0);
        // R3 write-1 keeps
        wr(2'd0, 8'hFF);
        rd("R3 write one keeps", 2'd0, 8'h01);
        // R8 clear drops irq right after the edge
        wr(2'd0, 8'hFE);
        rd("R3 clear alarm", 2'd0, 8'h00);
        check("R8 irq follows clear", irq_n, 1);

        // R4 event beats clear
        ts_event = 2'b10; reg_wr = 1; reg_addr = 2'd0; reg_wdata = 8'h00;
        tick(); reg_wr = 0; ts_event = 0;
        rd("R4 event wins", 2'd0, 8'h20);
        wr(2'd0, 8'h00);
        rd("R3 clear ts", 2'd0, 8'h00);

        // R5 watchdog
        wd_expire = 1; tick(); wd_expire = 0;
        wr(2'd0, 8'h00);
        rd("R5 write immune", 2'd0, 8'h04);
        check("R5 irq off field 0", irq_n, 1);
        wr(2'd2, 8'h02);
        check("R7 wd field 2 enables", irq_n, 0);
        wd_restart = 1; tick(); wd_restart = 0;
        rd("R5 restart clears", 2'd0, 8'h00);
        check("R8 irq after restart", irq_n, 1);
        wd_expire = 1; wd_restart = 1; tick(); wd_expire = 0; wd_restart = 0;
        rd("R5 expire wins", 2'd0, 8'h04);
        wd_restart = 1; tick(); wd_restart = 0;

        // R6 battery low
        bat_low = 1; tick();
        rd("R6 batlow tracks", 2'd0, 8'h08);
        wr(2'd0, 8'h00);
        rd("R6 write immune", 2'd0, 8'h08);
        wr(2'd1, 8'h08);
        check("R7 batlow irq", irq_n, 0);
        wr(2'd1, 8'h00);
        check("R8 enable removal", irq_n, 1);
        bat_low = 0; tick();
        rd("R6 batlow recovers", 2'd0, 8'h00);

        // R9 readback
        wr(2'd1, 8'hFF);
        rd("R9 enable readback", 2'd1, 8'h0F);
        wr(2'd2, 8'hFF);
        rd("R9 wdctl readback", 2'd2, 8'h03);
        wr(2'd3, 8'hFF);
        rd("R9 addr3 zero", 2'd3, 8'h00);
        rd("R9 enable unchanged", 2'd1, 8'h0F);

        // Sweep: R2 R3 R5 R6 R7 R8
        for (int e = 0; e < 16; e++) begin
            for (int c = 0; c < 4; c++) begin
                for (int p = 0; p < 64; p++) begin
                    logic a, s, w, b, t0, t1, wdon, exp_irq;
                    a = p[0]; s = p[1]; w = p[2]; b = p[3]; t0 = p[4]; t1 = p[5];
                    wdon = (c != 0);
                    do_reset();
                    wr(2'd1, 8'(e));
                    wr(2'd2, 8'(c));
                    alarm_hit = a; bat_switched = s; wd_expire = w;
                    bat_low = b; ts_event = {t1, t0};
                    tick();
                    alarm_hit = 0; bat_switched = 0; wd_expire = 0; ts_event = 0;
                    rd("R2 sweep status", 2'd0, 8'(p));
                    exp_irq = (a & e[0]) | (s & e[1]) | (w & wdon) |
                              (b & e[3]) | ((t0 | t1) & e[2]);
                    check("R7 sweep irq_n", irq_n, !exp_irq);
                    wr(2'd0, 8'h00);
                    rd("R3 sweep after clear", 2'd0, {4'b0, b, w, 2'b00});
                    exp_irq = (w & wdon) | (b & e[3]);
                    check("R8 sweep irq after clear", irq_n, !exp_irq);
                end
            end
        end
        bat_low = 0;

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule